// File: doc/BRIEF.md
# Floppy Flux Capture Trigger Controller

This block records the raw read-data line of a floppy drive into an external synchronous SRAM. The line is sampled once per acquisition clock, and the acquisition clock runs at 32 times the disc bit rate. Each group of consecutive samples is packed into one SRAM word, and the words are written to consecutive addresses. The controller is armed through a small register write port. It then waits for a programmable start event, captures samples, and ends the capture on a programmable stop event. After the capture ends, the address that the next word would have taken stays visible as the capture length.

The start event and the stop event are each chosen from four sources:
- a match of the programmable MFM sync word,
- a rising edge of the index pulse,
- a falling edge of the index pulse,
- a rising edge of the hard-sector mark.

Each event can be qualified with a count N, so that only the Nth occurrence triggers. One sync-word detector serves both conditions. It cuts the line into MFM cells of half a bit period each, and it compares the last cells it has seen against the programmed word. If the buffer fills completely, the capture stops by itself and an overflow flag is raised.

Top module: `flux_capture_ctrl`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `overflow_o` is 0, `end_addr_o` is 0 and no SRAM write occurs. The state codes are 0 idle, 1 armed, 2 capturing and 3 done.
- R2: A write of bit 0 set to register 0 (the arm command) moves the block from idle or done to armed on the next clock. It clears the write address, the overflow flag and both event counters. A write of bit 1 set to register 0 (the abort command) returns the block to idle from any state and clears the overflow flag. The block never passes from idle to capturing or done without going through armed.
- R3: Register 1 selects the start source in bits [1:0], with 0 for sync match, 1 for index rising edge, 2 for index falling edge and 3 for sector-mark rising edge. The index and sector inputs pass through a two-flop synchronizer before edge detection.
- R4: The count field in bits [6:2] of registers 1 and 2 makes a condition fire on the Nth qualifying event. A count of 0 acts as 1. Events that arrive while the condition is not being watched are not counted: the start condition is watched only while armed, and the stop condition only while capturing.
- R5: While capturing, one synchronized sample of the read line is taken on each clock. Every 8 samples form one byte, earliest sample in bit 7, and the bytes are written at consecutive addresses starting from 0. A line held high gives 0xFF and a line held low gives 0x00.
- R6: Register 2 selects the stop source and count with the same encoding as register 1. On stop the block enters done. From then on no further writes occur and `end_addr_o` holds the address after the last byte written. A partly filled byte is discarded.
- R7: The sync detector runs a cell timer from reset with a period of CLK_PER_BIT/2 clocks. A cell reads 1 if a rising edge of the synchronized read line occurred within it. `sync_hit_o` pulses for one clock when the last 16 cells, oldest first, equal register 3. This single detector feeds the start condition and the stop condition.
- R8: Writing the byte at the top address ends the capture. The block enters done, sets `overflow_o` to 1 and leaves `end_addr_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition clock, 32 times the bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 command, 1 start, 2 stop, 3 sync word |
| cfg_wdata | input | 16 | Register write data |
| rd_data_i | input | 1 | Raw read-data line, high marks a flux pulse |
| index_i | input | 1 | Index pulse, asynchronous |
| sector_i | input | 1 | Hard-sector mark, asynchronous |
| sram_we_o | output | 1 | SRAM write enable, one clock per byte |
| sram_addr_o | output | ADDR_W | SRAM write address |
| sram_wdata_o | output | DATA_W | SRAM write data |
| state_o | output | 2 | Controller state code |
| overflow_o | output | 1 | Capture ended by a full buffer |
| end_addr_o | output | ADDR_W | Next write address, frozen once the capture ends |
| sync_hit_o | output | 1 | Sync-word match pulse |

## Verification
The bench builds the block with ADDR_W set to 8, which gives a 256-byte buffer, and keeps the default sync width, count width and bit-rate ratio. The small buffer puts the wrap at the top address within about two thousand capture clocks, so the overflow stop and the zero end address can be observed. The default 16-clock cell lets the bench place flux pulses inside known cells and send exact sync words, near-miss words and repeated words.

// File: rtl/flux_cap_pkg.sv
// Shared constants for the flux capture controller.
// Assumes a two-bit event-source field and a two-bit register select.
package flux_cap_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_CAPT  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_t;

    localparam logic [1:0] SRC_SYNC     = 2'd0;
    localparam logic [1:0] SRC_IDX_RISE = 2'd1;
    localparam logic [1:0] SRC_IDX_FALL = 2'd2;
    localparam logic [1:0] SRC_SECTOR   = 2'd3;

    localparam logic [1:0] REG_CMD   = 2'd0;
    localparam logic [1:0] REG_START = 2'd1;
    localparam logic [1:0] REG_STOP  = 2'd2;
    localparam logic [1:0] REG_SYNC  = 2'd3;
endpackage

// File: rtl/flux_sync2.sv
// Two-flop synchronizer bank for asynchronous drive lines.
// Gives the synchronized level and its value one clock earlier, so the
// parent can form edges. Assumes inputs are slow compared with clk.
module flux_sync2 #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;

    // Capture, settle, then hold one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            lvl_o  <= '0;
            prev_o <= '0;
        end else begin
            meta_q <= async_i;
            lvl_o  <= meta_q;
            prev_o <= lvl_o;
        end
    end
endmodule

// File: rtl/flux_sync_detect.sv
// MFM sync-word detector shared by the start and stop conditions.
// A free-running timer cuts the stream into cells of CLK_PER_BIT/2 clocks.
// A cell is 1 when a flux rising edge fell inside it. match_o pulses for one
// clock after a cell boundary at which the last SYNC_W cells equal word_i.
// Assumes CLK_PER_BIT is at least 4, so a cell lasts at least two clocks.
module flux_sync_detect #(
    parameter int CLK_PER_BIT = 32,
    parameter int SYNC_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flux_rise_i,
    input  logic [SYNC_W-1:0] word_i,
    output logic              match_o
);
    localparam int CELL = CLK_PER_BIT / 2;
    localparam int TW   = (CELL > 1) ? $clog2(CELL) : 1;
    localparam logic [TW-1:0] LAST = TW'(CELL - 1);

    logic [TW-1:0]     timer_q;
    logic              seen_q;
    logic [SYNC_W-1:0] cells_q;
    logic [SYNC_W-1:0] cells_nx;

    assign cells_nx = {cells_q[SYNC_W-2:0], seen_q | flux_rise_i};

    // Cell timing, cell shift register and registered match pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timer_q <= '0;
            seen_q  <= 1'b0;
            cells_q <= '0;
            match_o <= 1'b0;
        end else begin
            match_o <= 1'b0;
            if (timer_q == LAST) begin
                timer_q <= '0;
                seen_q  <= 1'b0;
                cells_q <= cells_nx;
                match_o <= (cells_nx == word_i);
            end else begin
                timer_q <= timer_q + 1'b1;
                seen_q  <= seen_q | flux_rise_i;
            end
        end
    end

    // R7: a match is a single-clock pulse, never two in a row.
    assert_match_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |=> !match_o);
endmodule

// File: rtl/flux_event_qual.sv
// Counts qualifying events and fires on the Nth one (a count of 0 acts as 1).
// Counts only while enable_i is high. fire_o is combinational with the event.
// Assumes the parent stops enabling the counter once it has fired.
module flux_event_qual #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             enable_i,
    input  logic             ev_i,
    input  logic [CNT_W-1:0] target_i,
    output logic             fire_o
);
    logic [CNT_W:0] cnt_q;
    logic [CNT_W:0] need;

    assign need   = (target_i == '0) ? (CNT_W+1)'(1) : {1'b0, target_i};
    assign fire_o = enable_i && ev_i && ((cnt_q + 1'b1) >= need);

    // Occurrence counter, cleared when the controller is armed.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (enable_i && ev_i && !fire_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: counting past the target stays impossible while enabled.
    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_i && !clear_i && $stable(target_i) && $past(enable_i)) |-> (cnt_q < need));
endmodule

// File: rtl/flux_packer.sv
// Packs one sample per enabled clock into DATA_W-bit words, earliest sample
// in the MSB, and issues a registered SRAM write per full word at ascending
// addresses. wrap_o flags the clock in which the top address is being filled.
module flux_packer #(
    parameter int ADDR_W = 17,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              enable_i,
    input  logic              sample_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] data_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic              wrap_o
);
    localparam int BW = $clog2(DATA_W);
    localparam logic [BW-1:0] BLAST = BW'(DATA_W - 1);

    logic [DATA_W-1:0] sh_q;
    logic [BW-1:0]     bcnt_q;
    logic [ADDR_W-1:0] wr_q;
    logic [DATA_W-1:0] word_nx;

    assign word_nx     = {sh_q[DATA_W-2:0], sample_i};
    assign next_addr_o = wr_q;
    assign wrap_o      = enable_i && (bcnt_q == BLAST) && (wr_q == '1);

    // Sample shifting, word completion and write address advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            bcnt_q <= '0;
            wr_q   <= '0;
            we_o   <= 1'b0;
            addr_o <= '0;
            data_o <= '0;
        end else begin
            we_o <= 1'b0;
            if (clear_i) begin
                bcnt_q <= '0;
                wr_q   <= '0;
            end else if (enable_i) begin
                sh_q <= word_nx;
                if (bcnt_q == BLAST) begin
                    bcnt_q <= '0;
                    we_o   <= 1'b1;
                    addr_o <= wr_q;
                    data_o <= word_nx;
                    wr_q   <= wr_q + 1'b1;
                end else begin
                    bcnt_q <= bcnt_q + 1'b1;
                end
            end
        end
    end

    // R5: each write goes to the address just below the current pointer.
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we_o |-> (addr_o + 1'b1 == wr_q) || $past(clear_i));
endmodule

// File: rtl/flux_capture_ctrl.sv
// Floppy flux capture trigger controller, top level.
// Holds the configuration registers and the idle/armed/capturing/done
// sequence. Selects start and stop events from one shared sync detector and
// the synchronized index and sector lines, and drives the SRAM packer.
// Assumes clk runs at CLK_PER_BIT times the disc bit rate.
module flux_capture_ctrl
    import flux_cap_pkg::*;
#(
    parameter int ADDR_W      = 17,
    parameter int DATA_W      = 8,
    parameter int CLK_PER_BIT = 32,
    parameter int SYNC_W      = 16,
    parameter int CNT_W       = 5,
    parameter logic [SYNC_W-1:0] SYNC_INIT = 16'h4489
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [SYNC_W-1:0] cfg_wdata,
    input  logic              rd_data_i,
    input  logic              index_i,
    input  logic              sector_i,
    output logic              sram_we_o,
    output logic [ADDR_W-1:0] sram_addr_o,
    output logic [DATA_W-1:0] sram_wdata_o,
    output logic [1:0]        state_o,
    output logic              overflow_o,
    output logic [ADDR_W-1:0] end_addr_o,
    output logic              sync_hit_o
);
    cap_state_t        st_q;
    logic [1:0]        src_q [2];
    logic [CNT_W-1:0]  n_q   [2];
    logic [SYNC_W-1:0] word_q;
    logic [2:0]        lvl, prev;
    logic              rd_rise, idx_rise, idx_fall, sec_rise;
    logic [1:0]        ev, en, fire;
    logic              cmd_arm, cmd_abort, arm_go, wrap;

    flux_sync2 #(.W(3)) u_sync2 (
        .clk(clk), .rst_n(rst_n),
        .async_i({sector_i, index_i, rd_data_i}),
        .lvl_o(lvl), .prev_o(prev)
    );

    assign rd_rise  = lvl[0] & ~prev[0];
    assign idx_rise = lvl[1] & ~prev[1];
    assign idx_fall = ~lvl[1] & prev[1];
    assign sec_rise = lvl[2] & ~prev[2];

    flux_sync_detect #(.CLK_PER_BIT(CLK_PER_BIT), .SYNC_W(SYNC_W)) u_det (
        .clk(clk), .rst_n(rst_n), .flux_rise_i(rd_rise),
        .word_i(word_q), .match_o(sync_hit_o)
    );

    assign cmd_arm   = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[0];
    assign cmd_abort = cfg_we && (cfg_addr == REG_CMD) && cfg_wdata[1];
    assign arm_go    = cmd_arm && !cmd_abort && (st_q == ST_IDLE || st_q == ST_DONE);
    assign en        = {st_q == ST_CAPT, st_q == ST_ARMED};

    // Index 0 is the start condition, index 1 the stop condition.
    for (genvar k = 0; k < 2; k++) begin : g_cond
        assign ev[k] = (src_q[k] == SRC_SYNC)     ? sync_hit_o :
                       (src_q[k] == SRC_IDX_RISE) ? idx_rise   :
                       (src_q[k] == SRC_IDX_FALL) ? idx_fall   : sec_rise;

        flux_event_qual #(.CNT_W(CNT_W)) u_qual (
            .clk(clk), .rst_n(rst_n), .clear_i(arm_go),
            .enable_i(en[k]), .ev_i(ev[k]), .target_i(n_q[k]),
            .fire_o(fire[k])
        );
    end

    flux_packer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .clear_i(arm_go),
        .enable_i(st_q == ST_CAPT), .sample_i(lvl[0]),
        .we_o(sram_we_o), .addr_o(sram_addr_o), .data_o(sram_wdata_o),
        .next_addr_o(end_addr_o), .wrap_o(wrap)
    );

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q[0] <= SRC_IDX_RISE;
            src_q[1] <= SRC_IDX_RISE;
            n_q[0]   <= CNT_W'(1);
            n_q[1]   <= CNT_W'(1);
            word_q   <= SYNC_INIT;
        end else if (cfg_we) begin
            case (cfg_addr)
                REG_START: begin
                    src_q[0] <= cfg_wdata[1:0];
                    n_q[0]   <= cfg_wdata[2 +: CNT_W];
                end
                REG_STOP: begin
                    src_q[1] <= cfg_wdata[1:0];
                    n_q[1]   <= cfg_wdata[2 +: CNT_W];
                end
                REG_SYNC: word_q <= cfg_wdata;
                default: ;
            endcase
        end
    end

    // Capture sequence and overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            overflow_o <= 1'b0;
        end else if (cmd_abort) begin
            st_q       <= ST_IDLE;
            overflow_o <= 1'b0;
        end else if (arm_go) begin
            st_q       <= ST_ARMED;
            overflow_o <= 1'b0;
        end else begin
            case (st_q)
                ST_ARMED: if (fire[0]) st_q <= ST_CAPT;
                ST_CAPT: begin
                    if (fire[1] || wrap) st_q <= ST_DONE;
                    if (wrap) overflow_o <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign state_o = st_q;

    // R5: SRAM writes only follow a capturing clock.
    assert_we_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sram_we_o |-> $past(st_q == ST_CAPT));
    // R8: overflow is only ever seen in the done state.
    assert_ovf_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |-> (st_q == ST_DONE));
    // R2: idle can only lead to idle or armed.
    assert_no_skip_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |=> (st_q == ST_IDLE || st_q == ST_ARMED));
    // R6: the end address is frozen while done and not re-armed.
    assert_end_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE && $past(st_q == ST_DONE) && !arm_go) |=> $stable(end_addr_o));
endmodule

// File: tb/flux_capture_ctrl_tb_top.sv
// Bench for the flux capture controller: directed corner cases plus
// seeded random index/sector trials checked against a bench-side model.
module flux_capture_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 8;
    localparam int CELL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic        rd = 1'b0, idx = 1'b0, sec = 1'b0;
    logic        sram_we, overflow, sync_hit;
    logic [AW-1:0] sram_addr, end_addr;
    logic [7:0]  sram_wdata;
    logic [1:0]  state;

    int nvec = 0, nfail = 0, cyc = 0;
    int mon_next = 0, mon_count = 0;
    bit mon_chk_data = 0;
    logic [7:0] mon_data = 8'h00;

    flux_capture_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .rd_data_i(rd), .index_i(idx), .sector_i(sec),
        .sram_we_o(sram_we), .sram_addr_o(sram_addr), .sram_wdata_o(sram_wdata),
        .state_o(state), .overflow_o(overflow), .end_addr_o(end_addr),
        .sync_hit_o(sync_hit)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Write monitor for R5: consecutive addresses and constant data.
    always @(negedge clk) begin
        if (rst_n && sram_we) begin
            chk("R5 write address", int'(sram_addr), mon_next % (1 << AW));
            if (mon_chk_data) chk("R5 write data", int'(sram_wdata), int'(mon_data));
            mon_next  = mon_next + 1;
            mon_count = mon_count + 1;
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg(input logic [1:0] a, input logic [15:0] d);
        cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] cond(input int src, input int n);
        return 16'((n << 2) | src);
    endfunction

    task automatic arm();
        mon_next = 0; mon_count = 0;
        cfg(2'd0, 16'h0001);
    endtask

    task automatic abort_it();
        cfg(2'd0, 16'h0002);
    endtask

    task automatic idx_pulse();
        idx = 1'b1; wait_n(4); idx = 1'b0; wait_n(8);
    endtask

    task automatic sec_pulse();
        sec = 1'b1; wait_n(4); sec = 1'b0; wait_n(8);
    endtask

    task automatic send_cell(input bit b);
        while (cyc % CELL != 0) @(negedge clk);
        for (int i = 0; i < CELL; i++) begin
            rd = b && (i == 4 || i == 5);
            @(negedge clk);
        end
        rd = 1'b0;
    endtask

    task automatic send_word(input logic [15:0] w);
        for (int b = 15; b >= 0; b--) send_cell(w[b]);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL watchdog R1 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int ea;
        void'($urandom(32'h5eed_1234));
        wait_n(4);
        rst_n = 1'b1;
        wait_n(2);

        // R1: reset state.
        chk("R1 state", int'(state), 0);
        chk("R1 overflow", int'(overflow), 0);
        chk("R1 end address", int'(end_addr), 0);
        chk("R1 no write", mon_count, 0);

        // R3 R7: sync-word start, near miss first, then exact word.
        cfg(2'd3, 16'h4489);
        cfg(2'd1, cond(0, 1));
        cfg(2'd2, cond(3, 1));
        arm();
        chk("R2 armed", int'(state), 1);
        for (int i = 0; i < 4; i++) send_cell(1'b0);
        send_word(16'h4488);
        wait_n(2);
        chk("R7 near miss ignored", int'(state), 1);
        send_word(16'h4489);
        wait_n(2);
        chk("R7 sync start", int'(state), 2);

        // R5: line held high packs into 0xFF bytes.
        rd = 1'b1;
        wait_n(20);
        mon_data = 8'hFF; mon_chk_data = 1;
        wait_n(40);
        sec_pulse();
        mon_chk_data = 0;
        chk("R6 sector stop", int'(state), 3);
        chk("R6 end address", int'(end_addr), mon_next % (1 << AW));
        ea = mon_count;
        wait_n(30);
        chk("R6 no writes after stop", mon_count, ea);
        chk("R6 end address frozen", int'(end_addr), mon_next % (1 << AW));
        rd = 1'b0;

        // R4 R7: start on second sync, stop on shared detector.
        cfg(2'd1, cond(0, 2));
        cfg(2'd2, cond(0, 1));
        arm();
        for (int i = 0; i < 4; i++) send_cell(1'b0);
        send_word(16'h4489);
        wait_n(2);
        chk("R4 first of two", int'(state), 1);
        send_word(16'h4489);
        wait_n(2);
        chk("R4 second of two", int'(state), 2);
        send_word(16'h4489);
        wait_n(2);
        chk("R7 shared stop", int'(state), 3);

        // R4: count 0 acts as 1; R2 abort from capturing and armed.
        cfg(2'd1, cond(1, 0));
        cfg(2'd2, cond(3, 5));
        arm();
        idx_pulse();
        chk("R4 zero count", int'(state), 2);
        abort_it();
        chk("R2 abort capturing", int'(state), 0);
        wait_n(3);
        arm();
        abort_it();
        chk("R2 abort armed", int'(state), 0);
        wait_n(3);

        // R4: idle events not counted.
        cfg(2'd1, cond(2, 2));
        for (int i = 0; i < 3; i++) idx_pulse();
        chk("R4 idle stays idle", int'(state), 0);
        arm();
        idx_pulse();
        chk("R4 idle events ignored", int'(state), 1);
        idx_pulse();
        chk("R3 falling edge start", int'(state), 2);
        abort_it();
        wait_n(3);

        // R8: buffer overflow.
        cfg(2'd1, cond(1, 1));
        cfg(2'd2, cond(3, 31));
        arm();
        mon_data = 8'h00; mon_chk_data = 1;
        idx_pulse();
        wait_n(256 * 8 + 40);
        mon_chk_data = 0;
        chk("R8 done", int'(state), 3);
        chk("R8 overflow", int'(overflow), 1);
        chk("R8 end address", int'(end_addr), 0);
        chk("R8 write count", mon_count, 256);
        arm();
        chk("R2 arm clears overflow", int'(overflow), 0);
        abort_it();
        wait_n(3);

        // R3 R4 R6: seeded random trials on index and sector events.
        for (int t = 0; t < 12; t++) begin
            int ss, sn, ps, pn, ph, cnt;
            ss = 1 + int'($urandom % 3); sn = int'($urandom % 5);
            ps = 1 + int'($urandom % 3); pn = int'($urandom % 5);
            cfg(2'd1, cond(ss, sn));
            cfg(2'd2, cond(ps, pn));
            arm();
            mon_data = 8'h00; mon_chk_data = 1;
            ph = 1; cnt = 0;
            for (int p = 0; p < 20; p++) begin
                int evs[2], ne;
                if ($urandom % 2 == 0) begin
                    idx_pulse(); evs[0] = 1; evs[1] = 2; ne = 2;
                end else begin
                    sec_pulse(); evs[0] = 3; evs[1] = 0; ne = 1;
                end
                for (int e = 0; e < ne; e++) begin
                    if (ph == 1 && evs[e] == ss) begin
                        cnt++;
                        if (cnt >= ((sn == 0) ? 1 : sn)) begin ph = 2; cnt = 0; end
                    end else if (ph == 2 && evs[e] == ps) begin
                        cnt++;
                        if (cnt >= ((pn == 0) ? 1 : pn)) begin ph = 3; cnt = 0; end
                    end
                end
                chk("R3 R6 random state", int'(state), ph);
            end
            if (ph == 3) chk("R6 random end address", int'(end_addr), mon_next % (1 << AW));
            mon_chk_data = 0;
            abort_it();
            wait_n(3);
        end

        finish_run();
    end
endmodule